// File: doc/BRIEF.md
# Pulse-Interval Forward Link Decoder

This block turns the notch stream of a reader into symbols on a small local oscillator clock. The reader marks time with short notches, which pull the demodulated input low. Only the falling edge of a notch matters. The block measures the number of local clock cycles between successive falling edges. Because the local clock can be off by ten percent or more, no absolute durations are built in.

Every frame opens with four calibration intervals: a zero reference, a one reference, an end-of-frame reference and a check interval. The block stores these references. It then sorts each following interval into binary zero, binary one or end-of-frame, using ratios of the stored references.

The first eight data symbols of each frame are packed into a command byte. An external checker validates that byte's CRC. When its pass pulse arrives during a frame whose header was accepted, the block reports that it is in sync. Any timing fault drops the sync flag again.

Top module: `pie_fwd_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, `sym_valid`, `timing_err`, `cmd_valid` and `in_sync` are all 0.
- R2: For the first 64 clock cycles after reset is released, falling edges of `notch_i` are ignored. A notch in that window does not disturb the decoding of a later frame.
- R3: An interval is the number of clock cycles between two accepted falling edges of `notch_i`. The rising edge and the notch width have no effect on the result.
- R4: The first falling edge of a frame starts a header of four intervals, in this order: zero reference Z, one reference O, end reference E and check interval C. Let mid = floor((Z+O)/2) and th = E - floor(E/4). The header passes only if Z < O, O <= th and C <= mid. Otherwise `timing_err` pulses and no symbol is emitted.
- R5: After a header passes, each data interval d produces exactly one `sym_valid` strobe. The code on `sym_code` is 2'b00 (zero) if d <= mid, 2'b10 (end-of-frame) if d > th, and 2'b01 (one) otherwise. Code 2'b11 never appears.
- R6: An end-of-frame symbol closes the frame. The next falling edge starts a new header, and the new references replace the old ones.
- R7: An interval that reaches 255 cycles, in the header or in the data, pulses `timing_err` and aborts the frame without a symbol for that interval.
- R8: `in_sync` is set by a `crc_pass_i` pulse arriving after the current frame's header has passed and before the next frame starts. It is cleared by `timing_err`. It is not set by `crc_pass_i` at any other time.
- R9: The first 8 non-end data symbols of a frame form `cmd_byte`. The first symbol goes to bit 7, and a one symbol gives a 1 bit. Bits 7:2 carry the opcode and bits 1:0 the command CRC. `cmd_valid` pulses exactly once, one cycle after the eighth strobe. There is no pulse if the frame ends sooner.
- R10: `timing_err` lasts exactly one cycle per fault and is never high together with `sym_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| notch_i | input | 1 | Asynchronous demodulated notch, low during a notch |
| crc_pass_i | input | 1 | One-cycle pulse from the external command CRC checker |
| sym_valid | output | 1 | Strobe for one decoded symbol |
| sym_code | output | 2 | 00 zero, 01 one, 10 end-of-frame |
| timing_err | output | 1 | One-cycle pulse on a header or saturation fault |
| in_sync | output | 1 | Link synchronized flag |
| cmd_valid | output | 1 | Strobe when the command byte is complete |
| cmd_byte | output | 8 | Captured short command, opcode in bits 7:2 |

## Verification
The sweep runs over the data interval for several reference sets. A wrong stored reference or a wrong threshold therefore shows up as a wrong symbol code at the first interval that falls between the correct and the faulty boundary. That happens within one interval of the header. A wrong header index or a stuck frame state shows up as a missing end-of-frame symbol, or as a spurious `timing_err` on the next frame. A stuck sync or capture state is visible on `in_sync` or `cmd_valid` a few cycles after the frame that should have changed it.

// File: rtl/pie_pkg.sv
package pie_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_EOF  = 2'b10
  } sym_t;
endpackage

// File: rtl/pie_notch_sync.sv
module pie_notch_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic notch_i,
  output logic fall_o
);
  localparam int GW = $clog2(GUARD_CYC + 1);
  localparam logic [GW-1:0] GUARD_END = GW'(GUARD_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [GW-1:0]          guard_q;
  logic                   open;

  assign open = (guard_q == GUARD_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      prev_q  <= 1'b1;
      guard_q <= '0;
      fall_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], notch_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (!open) guard_q <= guard_q + 1'b1;
      fall_o <= open && prev_q && !sync_q[SYNC_STAGES-1];
    end
  end

  // R3: an accepted edge needs a high sample before it, so two edges never touch
  a_r3_edge_spacing: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pie_interval_timer.sv
module pie_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_i,
  output logic             iv_valid_o,
  output logic [CNT_W-1:0] iv_len_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      run_q      <= 1'b0;
      iv_valid_o <= 1'b0;
      iv_len_o   <= '0;
      sat_o      <= 1'b0;
    end else begin
      iv_valid_o <= 1'b0;
      sat_o      <= 1'b0;
      if (fall_i) begin
        iv_valid_o <= 1'b1;
        iv_len_o   <= cnt_q;
        cnt_q      <= {{(CNT_W-1){1'b0}}, 1'b1};
        run_q      <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == CNT_MAX) begin
          sat_o <= 1'b1;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: saturation is reported once per run
  a_r7_sat_single: assert property (@(posedge clk) disable iff (rst)
    sat_o |=> !sat_o);
endmodule

// File: rtl/pie_symbol_classifier.sv
module pie_symbol_classifier
  import pie_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iv_valid_i,
  input  logic [CNT_W-1:0] iv_len_i,
  input  logic             sat_i,
  output logic             sym_valid_o,
  output sym_t             sym_o,
  output logic             err_o,
  output logic             frame_start_o,
  output logic             hdr_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} st_t;

  st_t              st_q;
  logic [1:0]       idx_q;
  logic [CNT_W-1:0] z_q, o_q, e_q;
  logic [CNT_W:0]   zo_sum;
  logic [CNT_W-1:0] mid, eof_th;
  logic             hdr_pass, is_max;

  assign zo_sum   = {1'b0, z_q} + {1'b0, o_q};
  assign mid      = zo_sum[CNT_W:1];
  assign eof_th   = e_q - {2'b00, e_q[CNT_W-1:2]};
  assign is_max   = (iv_len_i == CNT_MAX);
  assign hdr_pass = (z_q < o_q) && (o_q <= eof_th) && (iv_len_i <= mid);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      idx_q         <= '0;
      z_q           <= '0;
      o_q           <= '0;
      e_q           <= '0;
      sym_valid_o   <= 1'b0;
      sym_o         <= SYM_ZERO;
      err_o         <= 1'b0;
      frame_start_o <= 1'b0;
      hdr_ok_o      <= 1'b0;
    end else begin
      sym_valid_o   <= 1'b0;
      err_o         <= 1'b0;
      frame_start_o <= 1'b0;
      if (sat_i && st_q != ST_IDLE) begin
        err_o    <= 1'b1;
        hdr_ok_o <= 1'b0;
        st_q     <= ST_IDLE;
      end else if (iv_valid_i) begin
        unique case (st_q)
          ST_IDLE: begin
            st_q          <= ST_HDR;
            idx_q         <= '0;
            frame_start_o <= 1'b1;
            hdr_ok_o      <= 1'b0;
          end
          ST_HDR: begin
            idx_q <= idx_q + 1'b1;
            if (is_max) begin
              err_o <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              unique case (idx_q)
                2'd0: z_q <= iv_len_i;
                2'd1: o_q <= iv_len_i;
                2'd2: e_q <= iv_len_i;
                default: begin
                  if (hdr_pass) begin
                    st_q     <= ST_DATA;
                    hdr_ok_o <= 1'b1;
                  end else begin
                    err_o <= 1'b1;
                    st_q  <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          default: begin
            if (is_max) begin
              err_o    <= 1'b1;
              hdr_ok_o <= 1'b0;
              st_q     <= ST_IDLE;
            end else begin
              sym_valid_o <= 1'b1;
              if (iv_len_i <= mid) begin
                sym_o <= SYM_ZERO;
              end else if (iv_len_i > eof_th) begin
                sym_o <= SYM_EOF;
                st_q  <= ST_IDLE;
              end else begin
                sym_o <= SYM_ONE;
              end
            end
          end
        endcase
      end
    end
  end

  // R5: only the three defined codes leave the classifier
  a_r5_code_legal: assert property (@(posedge clk) disable iff (rst)
    sym_valid_o |-> (sym_o == SYM_ZERO || sym_o == SYM_ONE || sym_o == SYM_EOF));
  // R6: after end-of-frame the next interval is a frame start, never a symbol
  a_r6_eof_closes: assert property (@(posedge clk) disable iff (rst)
    (sym_valid_o && sym_o == SYM_EOF) |=> !sym_valid_o);
endmodule

// File: rtl/pie_cmd_capture.sv
module pie_cmd_capture
  import pie_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start_i,
  input  logic             sym_valid_i,
  input  sym_t             sym_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o
);
  localparam int CW = $clog2(CMD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(CMD_W - 1);
  localparam logic [CW-1:0] FULL = CW'(CMD_W);

  logic [CMD_W-1:0] shreg_q;
  logic [CW-1:0]    bcnt_q;
  logic [CMD_W-1:0] shreg_nx;

  assign shreg_nx = {shreg_q[CMD_W-2:0], (sym_i == SYM_ONE)};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q     <= '0;
      bcnt_q      <= '0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (frame_start_i) begin
        bcnt_q <= '0;
      end else if (sym_valid_i && sym_i != SYM_EOF && bcnt_q < FULL) begin
        shreg_q <= shreg_nx;
        bcnt_q  <= bcnt_q + 1'b1;
        if (bcnt_q == LAST) begin
          cmd_valid_o <= 1'b1;
          cmd_o       <= shreg_nx;
        end
      end
    end
  end

  // R9: a completed byte always follows a symbol strobe by one cycle
  a_r9_cmd_after_sym: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> $past(sym_valid_i));
endmodule

// File: rtl/pie_fwd_decoder.sv
module pie_fwd_decoder
  import pie_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int GUARD_CYC   = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CMD_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             notch_i,
  input  logic             crc_pass_i,
  output logic             sym_valid,
  output logic [1:0]       sym_code,
  output logic             timing_err,
  output logic             in_sync,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_byte
);
  logic             fall;
  logic             iv_valid, iv_sat;
  logic [CNT_W-1:0] iv_len;
  sym_t             sym;
  logic             frame_start, hdr_ok;

  pie_notch_sync #(.SYNC_STAGES(SYNC_STAGES), .GUARD_CYC(GUARD_CYC)) u_sync (
    .clk(clk), .rst(rst), .notch_i(notch_i), .fall_o(fall));

  pie_interval_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .fall_i(fall),
    .iv_valid_o(iv_valid), .iv_len_o(iv_len), .sat_o(iv_sat));

  pie_symbol_classifier #(.CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst(rst), .iv_valid_i(iv_valid), .iv_len_i(iv_len), .sat_i(iv_sat),
    .sym_valid_o(sym_valid), .sym_o(sym), .err_o(timing_err),
    .frame_start_o(frame_start), .hdr_ok_o(hdr_ok));

  pie_cmd_capture #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst), .frame_start_i(frame_start),
    .sym_valid_i(sym_valid), .sym_i(sym),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd_byte));

  assign sym_code = sym;

  always_ff @(posedge clk) begin
    if (rst)                      in_sync <= 1'b0;
    else if (timing_err)          in_sync <= 1'b0;
    else if (crc_pass_i && hdr_ok) in_sync <= 1'b1;
  end

  // R10: a fault and a symbol never share a cycle
  a_r10_err_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sym_valid, timing_err}));
  // R8: sync only rises after a CRC pass
  a_r8_sync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> $past(crc_pass_i));
  // R8: a fault drops sync on the next cycle
  a_r8_err_drops: assert property (@(posedge clk) disable iff (rst)
    timing_err |=> !in_sync);
endmodule

// File: tb/sim_pie_fwd_decoder.sv
module sim_pie_fwd_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic notch = 1'b1;
  logic crc_pass = 1'b0;
  logic sym_valid, timing_err, in_sync, cmd_valid;
  logic [1:0] sym_code;
  logic [7:0] cmd_byte;

  always #10 clk = ~clk;

  pie_fwd_decoder u0 (
    .clk(clk), .rst(rst), .notch_i(notch), .crc_pass_i(crc_pass),
    .sym_valid(sym_valid), .sym_code(sym_code), .timing_err(timing_err),
    .in_sync(in_sync), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte));

  int checks = 0, fails = 0;
  int rx[0:63];
  int rx_n = 0, err_n = 0, ovl_n = 0, cmd_n = 0;
  int cmd_last = 0;
  int ivs[0:63];
  int niv = 0;
  int cyc = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sym_valid) begin
        if (rx_n < 64) rx[rx_n] = int'(sym_code);
        rx_n++;
      end
      if (timing_err) err_n++;
      if (sym_valid && timing_err) ovl_n++;
      if (cmd_valid) begin
        cmd_n++;
        cmd_last = int'(cmd_byte);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear();
    rx_n = 0; err_n = 0; cmd_n = 0; cmd_last = 0; niv = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; notch = 1'b1; crc_pass = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (70) @(negedge clk);
    clear();
  endtask

  task automatic hdr(input int z, input int o, input int e, input int c);
    ivs[0] = z; ivs[1] = o; ivs[2] = e; ivs[3] = c; niv = 4;
  endtask

  task automatic add(input int d);
    ivs[niv] = d; niv++;
  endtask

  task automatic send(input int w);
    for (int k = 0; k <= niv; k++) begin
      notch = 1'b0;
      repeat (w) @(negedge clk);
      notch = 1'b1;
      if (k < niv) repeat (ivs[k] - w) @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  function automatic int cls(input int d, input int z, input int o, input int e);
    int mid, th;
    mid = (z + o) / 2;
    th  = e - e / 4;
    if (d <= mid) return 0;
    if (d > th) return 2;
    return 1;
  endfunction

  function automatic int pack_rx();
    int p = 0;
    for (int i = 0; i < rx_n && i < 12; i++) p = p | (rx[i] << (2 * i));
    return p;
  endfunction

  task automatic chk_syms(input string tag, input int exp_n, input int exp_pack);
    chk(rx_n == exp_n, tag, rx_n, exp_n);
    chk(pack_rx() == exp_pack && err_n == 0, tag, pack_rx(), exp_pack);
  endtask

  task automatic send_cmd(input int b, input int nb);
    hdr(6, 12, 24, 6);
    for (int i = 7; i > 7 - nb; i--) add(((b >> (((i % 8) + 8) % 8)) & 1) ? 12 : 6);
    add(24);
    send(2);
  endtask

  initial begin
    int zs[4], os[4], es[4];
    zs = '{6, 8, 10, 5}; os = '{12, 14, 21, 9}; es = '{24, 30, 40, 20};

    // R1 reset state
    repeat (3) @(negedge clk);
    chk({sym_valid, timing_err, cmd_valid, in_sync} == 4'b0, "R1 during reset",
        int'({sym_valid, timing_err, cmd_valid, in_sync}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({sym_valid, timing_err, cmd_valid, in_sync} == 4'b0, "R1 after reset",
        int'({sym_valid, timing_err, cmd_valid, in_sync}), 0);

    // R2 notches inside the guard window are ignored
    repeat (3) @(negedge clk);
    notch = 1'b0; repeat (2) @(negedge clk); notch = 1'b1;
    repeat (20) @(negedge clk);
    notch = 1'b0; repeat (2) @(negedge clk); notch = 1'b1;
    repeat (50) @(negedge clk);
    clear();
    hdr(6, 12, 24, 6); add(12); add(6); add(24);
    send(2);
    chk_syms("R2 guard", 3, 1 | (0 << 2) | (2 << 4));

    // R5 sweep of data interval over several reference sets
    for (int r = 0; r < 4; r++) begin
      for (int d = 3; d <= es[r] + 4; d++) begin
        int c, en, ep;
        do_reset();
        hdr(zs[r], os[r], es[r], zs[r]); add(d); add(es[r]);
        send(2);
        c = cls(d, zs[r], os[r], es[r]);
        if (c == 2) begin en = 1; ep = 2; end
        else begin en = 2; ep = c | (2 << 2); end
        chk(rx_n == en && pack_rx() == ep && err_n == 0, "R5 sweep", pack_rx(), ep);
      end
    end

    // R3 wider notch gives the same symbols
    do_reset();
    hdr(8, 14, 30, 8); add(14); add(8); add(23); add(24);
    send(5);
    chk_syms("R3 wide notch", 4, 1 | (0 << 2) | (1 << 4) | (2 << 6));

    // R4 header boundary that still passes
    do_reset();
    hdr(6, 12, 16, 9); add(12); add(9); add(13);
    send(2);
    chk_syms("R4 boundary pass", 3, 1 | (0 << 2) | (2 << 4));

    // R4 header failures
    do_reset(); hdr(12, 12, 24, 12); add(6); add(24); send(2);
    chk(err_n == 1 && rx_n == 0, "R4 zero not below one", err_n, 1);
    do_reset(); hdr(10, 20, 24, 10); add(6); add(24); send(2);
    chk(err_n == 1 && rx_n == 0, "R4 one above end threshold", err_n, 1);
    do_reset(); hdr(6, 12, 24, 10); add(6); add(24); send(2);
    chk(err_n == 1 && rx_n == 0, "R4 check above midpoint", err_n, 1);
    chk(ovl_n == 0, "R10 no overlap", ovl_n, 0);

    // R7 saturation
    do_reset(); hdr(6, 12, 24, 6); add(254); send(2);
    chk_syms("R7 254 is end", 1, 2);
    do_reset(); hdr(6, 12, 24, 6); add(255); send(2);
    chk(err_n == 1 && rx_n == 0, "R7 255 in data", err_n, 1);
    do_reset(); hdr(6, 12, 24, 6); add(6); add(300); send(2);
    chk(err_n == 1 && rx_n == 1, "R7 300 in data", err_n, 1);
    do_reset(); hdr(6, 12, 300, 6); send(2);
    chk(err_n == 1 && rx_n == 0, "R7 saturated header", err_n, 1);
    chk(ovl_n == 0, "R10 no overlap after saturation", ovl_n, 0);

    // R6 back-to-back frames with new references
    do_reset();
    hdr(6, 12, 24, 6); add(12); add(3); add(24); send(2);
    chk_syms("R6 first frame", 3, 1 | (0 << 2) | (2 << 4));
    clear();
    hdr(10, 21, 40, 10); add(21); add(8); add(16); add(40); send(2);
    chk_syms("R6 second frame", 4, 1 | (0 << 2) | (1 << 4) | (2 << 6));

    // R8 sync flag
    do_reset();
    chk(in_sync == 1'b0, "R8 idle after reset", int'(in_sync), 0);
    crc_pass = 1'b1; @(negedge clk); crc_pass = 1'b0; repeat (3) @(negedge clk);
    chk(in_sync == 1'b0, "R8 pass without header", int'(in_sync), 0);
    hdr(6, 12, 24, 6); add(3); add(24); send(2);
    crc_pass = 1'b1; @(negedge clk); crc_pass = 1'b0; repeat (3) @(negedge clk);
    chk(in_sync == 1'b1, "R8 set by pass", int'(in_sync), 1);
    clear(); hdr(12, 12, 24, 12); send(2);
    chk(in_sync == 1'b0 && err_n == 1, "R8 cleared by fault", int'(in_sync), 0);
    crc_pass = 1'b1; @(negedge clk); crc_pass = 1'b0; repeat (3) @(negedge clk);
    chk(in_sync == 1'b0, "R8 pass after failed header", int'(in_sync), 0);
    chk(err_n == 1, "R10 single-cycle pulse", err_n, 1);

    // R9 command capture
    begin
      int bytes[4];
      bytes = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
      for (int i = 0; i < 4; i++) begin
        do_reset(); send_cmd(bytes[i], 8);
        chk(cmd_n == 1 && cmd_last == bytes[i], "R9 byte", cmd_last, bytes[i]);
      end
    end
    do_reset(); send_cmd(8'hB4, 5);
    chk(cmd_n == 0, "R9 short frame", cmd_n, 0);
    do_reset();
    hdr(6, 12, 24, 6);
    add(12); add(6); add(6); add(12); add(12); add(12); add(6); add(12);
    add(12); add(6); add(24);
    send(2);
    chk(cmd_n == 1 && cmd_last == 8'h9D, "R9 long frame", cmd_last, 8'h9D);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule